// File: doc/BRIEF.md
# Card Response Token Receiver

This block is the host-side receiver for the short, 48-bit response tokens that a card returns on the command line of an MMC-style card bus. A host controller arms it after sending a command and tells it which response shape to expect. The receiver then watches the serial line on each rising edge of the bus clock. It takes the first low level as the start of a token and shifts in the 48 bits, most significant bit first. At the end it splits the token into its fields and checks it.

Three response shapes are handled. The operating-conditions response carries a fixed all-ones index and a fixed all-ones trailer instead of a checksum. The fast I/O and interrupt responses each carry a fixed command index and a CRC7 trailer that must match. The result comes out as a one-cycle pulse, together with the index, the 32-bit payload and three error flags. If no start bit shows up within a programmable number of clocks after arming, a no-response pulse is raised instead.

Top module: `rsp_token_rx`

## Requirements
- R1: While not armed the receiver ignores the line: a low level raises neither busy nor rsp_valid. Once armed, the first low sample counts as the token's start bit.
- R2: A token is 48 bits, most significant bit first. rsp_index reports bits [45:40] and rsp_arg reports bits [39:8], both held after the result. rsp_valid is a one-cycle pulse, seen SYNC_STAGES+1 rising edges after the edge at which bit 0 is present on cmd_line.
- R3: frame_err is raised with the result when bit 46 (direction, must be 0) is 1 or when bit 0 (stop, must be 1) is 0.
- R4: exp_type is sampled at arming: 0 selects the operating-conditions shape, 1 the fast I/O shape, and 2 or 3 the interrupt shape. idx_err is raised when bits [45:40] differ from 111111, 100111 or 101000 respectively.
- R5: For the operating-conditions shape, bits [7:1] must read 1111111, else frame_err is raised. crc_err is never raised for this shape.
- R6: For the fast I/O and interrupt shapes, a CRC7 with polynomial x^7+x^3+1 and zero start value is formed over bits 47 down to 8. crc_err is raised when it differs from bits [7:1].
- R7: With to_lim = N > 0, if the line stays high for the first N rising edges after the arming edge, no_rsp pulses for one cycle after the Nth edge and the block returns to idle. A start bit sampled on that Nth edge wins over the timeout.
- R8: to_lim = 0 disables the timeout: the block waits for a start bit without limit.
- R9: arm is ignored while busy. A pulse during reception neither restarts it nor changes the expected shape.
- R10: The three error flags are zero whenever rsp_valid is low, and busy is low in the cycle that rsp_valid or no_rsp is high.
- R11: After reset: busy, rsp_valid, no_rsp and all flags are 0, and rsp_index and rsp_arg are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start waiting for a response (taken only when idle) |
| exp_type | input | 2 | Expected response shape, sampled with arm |
| to_lim | input | TO_W (16) | Clocks to wait for a start bit; 0 waits forever |
| cmd_line | input | 1 | Serial command line, high when idle |
| busy | output | 1 | Armed or receiving |
| rsp_valid | output | 1 | One-cycle pulse: a token was received |
| rsp_index | output | IDX_W (6) | Index field of the last token |
| rsp_arg | output | ARG_W (32) | Payload field of the last token |
| crc_err | output | 1 | CRC7 mismatch, qualified by rsp_valid |
| frame_err | output | 1 | Direction, stop or fixed trailer wrong, qualified by rsp_valid |
| idx_err | output | 1 | Index differs from the expected shape, qualified by rsp_valid |
| no_rsp | output | 1 | One-cycle pulse: no start bit before the timeout |

## Verification
The result is due SYNC_STAGES+1 rising edges after the edge that first sees bit 0 on cmd_line. The bench drives each bit on a falling edge, waits that exact count of rising edges and samples on the next falling edge. It then checks on the falling edge after that, where the pulse must be gone. The no-response pulse is due right after the to_lim-th rising edge following the arming edge. It is sampled one edge before that (still absent) and on that edge (present). The start-versus-timeout race places the start bit on the line so that it reaches the control logic exactly on that edge.

// File: rtl/rsp_rx_pkg.sv
package rsp_rx_pkg;

   typedef enum logic [1:0] {
      KIND_OCR  = 2'd0,
      KIND_FIO  = 2'd1,
      KIND_IRQ  = 2'd2
   } rsp_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_SHIFT = 2'd2
   } rx_state_e;

   // Shape selector: 0 -> OCR, 1 -> fast I/O, 2 and 3 -> interrupt
   function automatic rsp_kind_e decode_kind(input logic [1:0] sel);
      case (sel)
         2'd0:    return KIND_OCR;
         2'd1:    return KIND_FIO;
         default: return KIND_IRQ;
      endcase
   endfunction

endpackage

// File: rtl/rsp_rx_sync.sv
module rsp_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) q[0] <= 1'b1;
                  else        q[0] <= din;
               end
            end else begin : g_tail
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) q[i] <= 1'b1;
                  else        q[i] <= q[i-1];
               end
            end
         end
         assign dout = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rsp_rx_crc.sv
module rsp_rx_crc #(
   parameter int           W    = 7,
   parameter logic [W-1:0] POLY = 7'h09
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);

   logic [W-1:0] base;
   logic [W-1:0] nxt;
   logic         fb;

   assign base = clr ? '0 : crc;
   assign fb   = din ^ base[W-1];

   generate
      for (genvar i = 0; i < W; i++) begin : g_tap
         if (i == 0) begin : g_lsb
            assign nxt[0] = POLY[0] & fb;
         end else begin : g_mid
            assign nxt[i] = base[i-1] ^ (POLY[i] & fb);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (en)  crc <= nxt;
      else if (clr) crc <= '0;
   end

endmodule

// File: rtl/rsp_rx_ctrl.sv
module rsp_rx_ctrl
   import rsp_rx_pkg::*;
#(
   parameter int TOKEN_W  = 48,
   parameter int CRC_SPAN = 40,
   parameter int TO_W     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm,
   input  logic               line,
   input  logic [TO_W-1:0]    to_lim,
   output logic               busy,
   output logic               accept,
   output logic               crc_clr,
   output logic               crc_en,
   output logic               done,
   output logic               timeout,
   output logic [TOKEN_W-1:0] token
);

   localparam int CNT_W = $clog2(TOKEN_W + 1);

   rx_state_e          st_q, st_d;
   logic [CNT_W-1:0]   bit_q;
   logic [TO_W-1:0]    wait_q;
   logic [TOKEN_W-2:0] sr_q;
   logic               start_hit, in_shift, take;

   assign start_hit = (st_q == ST_WAIT) && !line;
   assign in_shift  = (st_q == ST_SHIFT);
   assign take      = start_hit || in_shift;
   assign done      = in_shift && (bit_q == CNT_W'(TOKEN_W - 1));
   assign timeout   = (st_q == ST_WAIT) && line && (to_lim != '0)
                      && (wait_q == to_lim - 1'b1);
   assign accept    = (st_q == ST_IDLE) && arm;
   assign crc_clr   = start_hit;
   assign crc_en    = take && (bit_q < CNT_W'(CRC_SPAN));
   assign token     = {sr_q, line};
   assign busy      = (st_q != ST_IDLE);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (arm) st_d = ST_WAIT;
         ST_WAIT: begin
            if (start_hit)    st_d = ST_SHIFT;
            else if (timeout) st_d = ST_IDLE;
         end
         ST_SHIFT: if (done) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bit_q  <= '0;
         wait_q <= '0;
         sr_q   <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            bit_q  <= '0;
            wait_q <= '0;
         end
         if (take) begin
            sr_q  <= {sr_q[TOKEN_W-3:0], line};
            bit_q <= bit_q + 1'b1;
         end
         if ((st_q == ST_WAIT) && line) wait_q <= wait_q + 1'b1;
      end
   end

endmodule

// File: rtl/rsp_rx_fields.sv
module rsp_rx_fields
   import rsp_rx_pkg::*;
#(
   parameter int IDX_W      = 6,
   parameter int ARG_W      = 32,
   parameter int CRC_W      = 7,
   parameter int IDX_FIO    = 39,
   parameter int IDX_IRQ    = 40,
   parameter bit RSVD_CHECK = 1'b1,
   localparam int TOKEN_W   = 3 + IDX_W + ARG_W + CRC_W
) (
   input  logic [TOKEN_W-1:0] token,
   input  rsp_kind_e          kind,
   input  logic [CRC_W-1:0]   crc_calc,
   output logic [IDX_W-1:0]   idx,
   output logic [ARG_W-1:0]   arg,
   output logic               frame_bad,
   output logic               idx_bad,
   output logic               crc_bad
);

   localparam int CRC_LSB   = 1;
   localparam int ARG_LSB   = CRC_LSB + CRC_W;
   localparam int IDX_LSB   = ARG_LSB + ARG_W;
   localparam int DIR_POS   = IDX_LSB + IDX_W;
   localparam int START_POS = DIR_POS + 1;

   logic [CRC_W-1:0] trailer;
   logic [IDX_W-1:0] idx_ref;
   logic             base_bad, rsvd_bad;

   assign idx      = token[IDX_LSB +: IDX_W];
   assign arg      = token[ARG_LSB +: ARG_W];
   assign trailer  = token[CRC_LSB +: CRC_W];
   assign base_bad = token[START_POS] | token[DIR_POS] | ~token[0];

   generate
      if (RSVD_CHECK) begin : g_rsvd_on
         assign rsvd_bad = (kind == KIND_OCR) && (trailer != '1);
      end else begin : g_rsvd_off
         assign rsvd_bad = 1'b0;
      end
   endgenerate

   always_comb begin
      case (kind)
         KIND_OCR: idx_ref = '1;
         KIND_FIO: idx_ref = IDX_W'(IDX_FIO);
         default:  idx_ref = IDX_W'(IDX_IRQ);
      endcase
   end

   assign frame_bad = base_bad | rsvd_bad;
   assign idx_bad   = (idx != idx_ref);
   assign crc_bad   = (kind != KIND_OCR) && (trailer != crc_calc);

endmodule

// File: rtl/rsp_token_rx.sv
module rsp_token_rx
   import rsp_rx_pkg::*;
#(
   parameter int               IDX_W       = 6,
   parameter int               ARG_W       = 32,
   parameter int               CRC_W       = 7,
   parameter logic [CRC_W-1:0] CRC_POLY    = 7'h09,
   parameter int               TO_W        = 16,
   parameter int               SYNC_STAGES = 2,
   parameter int               IDX_FIO     = 39,
   parameter int               IDX_IRQ     = 40,
   parameter bit               RSVD_CHECK  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [1:0]       exp_type,
   input  logic [TO_W-1:0]  to_lim,
   input  logic             cmd_line,
   output logic             busy,
   output logic             rsp_valid,
   output logic [IDX_W-1:0] rsp_index,
   output logic [ARG_W-1:0] rsp_arg,
   output logic             crc_err,
   output logic             frame_err,
   output logic             idx_err,
   output logic             no_rsp
);

   localparam int TOKEN_W  = 3 + IDX_W + ARG_W + CRC_W;
   localparam int CRC_SPAN = TOKEN_W - CRC_W - 1;

   generate
      if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
         $error("CRC polynomial must have its constant term set");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
      if (TO_W < 1 || TO_W > 32) begin : g_bad_to
         $error("TO_W must be within 1..32");
      end
      if (IDX_FIO >= (1 << IDX_W) || IDX_IRQ >= (1 << IDX_W)) begin : g_bad_idx
         $error("Index constants must fit IDX_W bits");
      end
   endgenerate

   logic               line_s;
   logic               accept, crc_clr, crc_en, done, timeout;
   logic [TOKEN_W-1:0] token;
   logic [CRC_W-1:0]   crc_calc;
   rsp_kind_e          typ_q;
   logic [IDX_W-1:0]   f_idx;
   logic [ARG_W-1:0]   f_arg;
   logic               f_frame, f_idx_bad, f_crc;

   rsp_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cmd_line),
      .dout (line_s)
   );

   rsp_rx_ctrl #(
      .TOKEN_W (TOKEN_W),
      .CRC_SPAN(CRC_SPAN),
      .TO_W    (TO_W)
   ) ctrl_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm),
      .line   (line_s),
      .to_lim (to_lim),
      .busy   (busy),
      .accept (accept),
      .crc_clr(crc_clr),
      .crc_en (crc_en),
      .done   (done),
      .timeout(timeout),
      .token  (token)
   );

   rsp_rx_crc #(.W(CRC_W), .POLY(CRC_POLY)) crc_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (crc_clr),
      .en   (crc_en),
      .din  (line_s),
      .crc  (crc_calc)
   );

   rsp_rx_fields #(
      .IDX_W     (IDX_W),
      .ARG_W     (ARG_W),
      .CRC_W     (CRC_W),
      .IDX_FIO   (IDX_FIO),
      .IDX_IRQ   (IDX_IRQ),
      .RSVD_CHECK(RSVD_CHECK)
   ) fields_i (
      .token    (token),
      .kind     (typ_q),
      .crc_calc (crc_calc),
      .idx      (f_idx),
      .arg      (f_arg),
      .frame_bad(f_frame),
      .idx_bad  (f_idx_bad),
      .crc_bad  (f_crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         typ_q     <= KIND_OCR;
         rsp_valid <= 1'b0;
         no_rsp    <= 1'b0;
         rsp_index <= '0;
         rsp_arg   <= '0;
         crc_err   <= 1'b0;
         frame_err <= 1'b0;
         idx_err   <= 1'b0;
      end else begin
         if (accept) typ_q <= decode_kind(exp_type);
         rsp_valid <= done;
         no_rsp    <= timeout;
         crc_err   <= done & f_crc;
         frame_err <= done & f_frame;
         idx_err   <= done & f_idx_bad;
         if (done) begin
            rsp_index <= f_idx;
            rsp_arg   <= f_arg;
         end
      end
   end

endmodule

// File: rtl/rsp_token_rx_chk.sv
module rsp_token_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       arm,
   input logic       busy,
   input logic       rsp_valid,
   input logic       no_rsp,
   input logic       crc_err,
   input logic       frame_err,
   input logic       idx_err,
   input logic [1:0] kind
);

   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R10
   flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err || frame_err || idx_err) |-> rsp_valid);

   // R10
   idle_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || no_rsp) |-> !busy);

   // R7
   result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !no_rsp);

   // R7
   no_rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      no_rsp |=> !no_rsp);

   // R5
   ocr_no_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && kind == 2'd0) |-> !crc_err);

   // R9
   arm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(arm));

endmodule

bind rsp_token_rx rsp_token_rx_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .arm      (arm),
   .busy     (busy),
   .rsp_valid(rsp_valid),
   .no_rsp   (no_rsp),
   .crc_err  (crc_err),
   .frame_err(frame_err),
   .idx_err  (idx_err),
   .kind     (typ_q)
);

// File: tb/rsp_token_rx_tb_top.sv
module rsp_token_rx_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic [1:0]  exp_type = 2'd0;
   logic [15:0] to_lim = 16'd100;
   logic        cmd_line = 1'b1;
   logic        busy, rsp_valid, crc_err, frame_err, idx_err, no_rsp;
   logic [5:0]  rsp_index;
   logic [31:0] rsp_arg;

   int checks = 0;
   int errors = 0;
   int vcnt = 0;
   int ncnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rsp_token_rx #(.SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .exp_type(exp_type),
      .to_lim(to_lim), .cmd_line(cmd_line), .busy(busy),
      .rsp_valid(rsp_valid), .rsp_index(rsp_index), .rsp_arg(rsp_arg),
      .crc_err(crc_err), .frame_err(frame_err), .idx_err(idx_err),
      .no_rsp(no_rsp)
   );

   always @(negedge clk) begin
      if (rsp_valid) vcnt++;
      if (no_rsp)    ncnt++;
   end

   typedef struct packed {
      logic [1:0]  typ;
      logic [5:0]  idx;
      logic [31:0] arg;
      logic [2:0]  mode;   // 0 clean, 1 flip bit1, 2 dir=1, 3 stop=0, 4 bit1=0
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{2'd0, 6'h3F, 32'hA5A5_0F0F, 3'd0},
      '{2'd1, 6'h27, 32'h1234_5678, 3'd0},
      '{2'd2, 6'h28, 32'hDEAD_BEEF, 3'd0},
      '{2'd1, 6'h27, 32'h0000_0001, 3'd1},
      '{2'd2, 6'h28, 32'hFFFF_FFFF, 3'd2},
      '{2'd0, 6'h3F, 32'h80FF_8000, 3'd3},
      '{2'd0, 6'h3F, 32'h0000_0000, 3'd4},
      '{2'd1, 6'h28, 32'hCAFE_0001, 3'd0},
      '{2'd3, 6'h28, 32'h1357_9BDF, 3'd0},
      '{2'd0, 6'h27, 32'h7654_3210, 3'd0},
      '{2'd2, 6'h27, 32'h0F0F_F0F0, 3'd3},
      '{2'd0, 6'h3F, 32'h0000_0000, 3'd1}
   };

   function automatic logic [6:0] ref_crc(input logic [39:0] bits);
      logic [6:0] r = '0;
      for (int i = 39; i >= 0; i--) begin
         logic fb = bits[i] ^ r[6];
         r = {r[5:0], 1'b0};
         if (fb) r = r ^ 7'h09;
      end
      return r;
   endfunction

   function automatic logic [5:0] ref_idx(input logic [1:0] t);
      case (t)
         2'd0:    return 6'b111111;
         2'd1:    return 6'b100111;
         default: return 6'b101000;
      endcase
   endfunction

   function automatic logic [47:0] build_tok(input vec_t v);
      logic [47:0] t = {2'b00, v.idx, v.arg, 7'h00, 1'b1};
      if (v.typ == 2'd0) t[7:1] = 7'h7F;
      else               t[7:1] = ref_crc(t[47:8]);
      case (v.mode)
         3'd1: t[1]  = ~t[1];
         3'd2: t[46] = 1'b1;
         3'd3: t[0]  = 1'b0;
         3'd4: t[1]  = 1'b0;
         default: ;
      endcase
      return t;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_arm(input logic [1:0] t, input logic [15:0] lim);
      @(negedge clk);
      arm = 1'b1; exp_type = t; to_lim = lim;
      @(negedge clk);
      arm = 1'b0;
   endtask

   // starts driving on the current falling edge; ends on the falling edge
   // after bit 0 was taken by the first rising edge
   task automatic send_tok(input logic [47:0] tok);
      for (int i = 47; i >= 0; i--) begin
         cmd_line = tok[i];
         @(negedge clk);
      end
      cmd_line = 1'b1;
   endtask

   task automatic wait_result();
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_result(input string tag, input logic [1:0] typ, input logic [47:0] tok);
      logic r3 = (typ == 2'd0);
      logic e_frame = tok[46] | ~tok[0] | (r3 && tok[7:1] != 7'h7F);
      logic e_crc   = !r3 && (ref_crc(tok[47:8]) != tok[7:1]);
      logic e_idx   = (tok[45:40] != ref_idx(typ));
      chk({tag, " R2 valid"}, rsp_valid, 1'b1);
      chk({tag, " R2 index"}, rsp_index, tok[45:40]);
      chk({tag, " R2 arg"}, rsp_arg, tok[39:8]);
      chk({tag, " R3/R5 frame_err"}, frame_err, e_frame);
      chk({tag, " R4 idx_err"}, idx_err, e_idx);
      chk({tag, " R6 crc_err"}, crc_err, e_crc);
      @(negedge clk);
      chk({tag, " R2/R10 pulse end"}, {rsp_valid, crc_err, frame_err, idx_err}, 4'b0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int v0, n0;
      logic [47:0] tok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 reset flags", {busy, rsp_valid, no_rsp, crc_err, frame_err, idx_err}, 6'b0);
      chk("R11 reset fields", {rsp_index, rsp_arg}, 38'b0);

      // R1 low on the line while idle is ignored
      v0 = vcnt;
      cmd_line = 1'b0;
      repeat (20) @(negedge clk);
      chk("R1 idle busy", busy, 1'b0);
      cmd_line = 1'b1;
      repeat (SYNC + 2) @(negedge clk);
      @(posedge clk);
      chk("R1 idle no result", vcnt - v0, 0);

      // vector table (R2..R6)
      for (int v = 0; v < 12; v++) begin
         tok = build_tok(VECS[v]);
         do_arm(VECS[v].typ, 16'd100);
         send_tok(tok);
         wait_result();
         check_result($sformatf("vec%0d", v), VECS[v].typ, tok);
         repeat (2) @(negedge clk);
      end

      // R7 timeout fires after the to_lim-th edge
      do_arm(2'd1, 16'd5);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R7 before limit", {no_rsp, busy}, 2'b01);
      @(negedge clk);
      chk("R7 no_rsp pulse", {no_rsp, busy, rsp_valid}, 3'b100);
      @(negedge clk);
      chk("R7 no_rsp one cycle", no_rsp, 1'b0);

      // R7 start bit on the limit edge wins
      n0 = ncnt;
      tok = build_tok('{2'd2, 6'h28, 32'h0BAD_F00D, 3'd0});
      do_arm(2'd2, 16'd6);
      repeat (6 - SYNC - 1) @(negedge clk);
      send_tok(tok);
      wait_result();
      check_result("R7 race", 2'd2, tok);
      @(posedge clk);
      chk("R7 race no timeout", ncnt - n0, 0);

      // R8 zero limit waits forever
      n0 = ncnt;
      do_arm(2'd1, 16'd0);
      repeat (60) @(negedge clk);
      @(posedge clk);
      chk("R8 no timeout", ncnt - n0, 0);
      @(negedge clk);
      chk("R8 still busy", busy, 1'b1);
      tok = build_tok('{2'd1, 6'h27, 32'h4444_2222, 3'd0});
      send_tok(tok);
      wait_result();
      check_result("R8 late token", 2'd1, tok);

      // R9 arm during reception is ignored
      tok = build_tok('{2'd1, 6'h27, 32'h600D_CAFE, 3'd0});
      do_arm(2'd1, 16'd100);
      for (int i = 47; i >= 0; i--) begin
         cmd_line = tok[i];
         if (i == 20) begin arm = 1'b1; exp_type = 2'd0; end
         else arm = 1'b0;
         @(negedge clk);
      end
      cmd_line = 1'b1;
      arm = 1'b0;
      wait_result();
      check_result("R9 mid arm", 2'd1, tok);
      chk("R9 idle after", busy, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule